// File: doc/BRIEF.md
# ECC Fault Status Capture Register

This block sits next to a memory read path and records error-correction faults in a small sticky status register. Each accepted read comes with two indications from the decoder: one says a single-bit error was corrected, and the other says an uncorrectable double-bit error was found. The block classifies each read and latches the result into one of two flags. A separate flag pattern marks a read that was attempted while the command engine was busy. Such a read returns invalid data, so the block sets both flags together.

Software reads the flags through a small register port and clears them by writing ones. Each flag can raise its own interrupt request when the matching enable bit is set in a local control register. The flags update one clock after the read that caused them. A configuration input can suppress reporting of corrected single-bit faults. It does not suppress the collision marking.

Top module: `ecc_fault_capture`

## Requirements
- R1: At register address 0 and on `status`, bit 1 is the double-fault flag and bit 0 is the single-fault flag. Bits 7 to 2 always read 0.
- R2: A register write to address 0 clears each flag whose `reg_wdata` bit is 1. A flag whose write bit is 0 keeps its value.
- R3: A read sampled with `cmd_busy` low sets exactly one flag. If `dbit_err` is high it sets only bit 1, even when `sbit_fix` is also high. Otherwise, if `sbit_fix` is high, it sets only bit 0.
- R4: A read sampled with `cmd_busy` high sets both bits 1 and 0. This holds whatever `sbit_fix`, `dbit_err` and `ign_single` are.
- R5: A read sampled at clock edge t changes the flags only at edge t+1. After edge t the status does not yet show it.
- R6: When `ign_single` is high, a corrected single-bit fault on a non-colliding read leaves bit 0 unchanged.
- R7: If a flag is set by a read and cleared by a register write at the same edge, the flag ends up set.
- R8: Register address 1 is the interrupt enable register. Bit 1 enables `irq_dbl` and bit 0 enables `irq_sgl`. Bits 7 to 2 read 0.
- R9: `irq_dbl` equals flag bit 1 AND enable bit 1, and `irq_sgl` equals flag bit 0 AND enable bit 0.
- R10: Synchronous reset clears both flags and both enable bits.
- R11: While `rd_valid` is low, `sbit_fix`, `dbit_err` and `cmd_busy` have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | A memory read is sampled this cycle |
| sbit_fix | input | 1 | Decoder corrected a single-bit error |
| dbit_err | input | 1 | Decoder found an uncorrectable double-bit error |
| cmd_busy | input | 1 | Command engine is active |
| ign_single | input | 1 | Suppress single-bit fault reporting |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 interrupt enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| status | output | 8 | Status register contents |
| irq_sgl | output | 1 | Single-fault interrupt request |
| irq_dbl | output | 1 | Double-fault interrupt request |

## Verification
The main sweep tries all sixteen combinations of `sbit_fix`, `dbit_err`, `cmd_busy` and `ign_single` on a read that starts from cleared flags. For each one it checks that the status is still zero after the first edge and matches the expected pattern after the second. This separates collision marking from a genuine double fault, double-over-single priority, and the effect of the mask. Further patterns cover:
- single-bit clears, which show that each write bit affects only its own flag;
- a clear written in the same edge as a pending set, which shows that the set wins;
- toggling decoder inputs with `rd_valid` low;
- each combination of enable bit and flag on the interrupt lines.

// File: rtl/ecc_fault_pkg.sv
package ecc_fault_pkg;
  localparam int FLAG_N  = 2;
  localparam int SGL_IDX = 0;
  localparam int DBL_IDX = 1;
  localparam logic ADDR_STAT = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/fault_classify.sv
module fault_classify
  import ecc_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  input  logic              sbit_fix,
  input  logic              dbit_err,
  input  logic              cmd_busy,
  input  logic              ign_single,
  output logic [FLAG_N-1:0] set_q
);
  logic [FLAG_N-1:0] set_d;

  always_comb begin
    set_d = '0;
    if (rd_valid) begin
      if (cmd_busy) begin
        set_d = '1;
      end else if (dbit_err) begin
        set_d[DBL_IDX] = 1'b1;
      end else if (sbit_fix && !ign_single) begin
        set_d[SGL_IDX] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) set_q <= '0;
    else     set_q <= set_d;
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (rst)     en_q <= '0;
    else if (we) en_q <= wdata;
  end
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
  import ecc_fault_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  input  logic             sbit_fix,
  input  logic             dbit_err,
  input  logic             cmd_busy,
  input  logic             ign_single,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [REG_W-1:0] status,
  output logic             irq_sgl,
  output logic             irq_dbl
);
  localparam int PAD_W = REG_W - FLAG_N;

  logic [FLAG_N-1:0] set_pend;
  logic [FLAG_N-1:0] clr_req;
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] irq_en;
  logic              ctrl_we;

  fault_classify u_cls (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .sbit_fix(sbit_fix),
    .dbit_err(dbit_err), .cmd_busy(cmd_busy), .ign_single(ign_single),
    .set_q(set_pend)
  );

  assign clr_req = (reg_we && reg_addr == ADDR_STAT) ? reg_wdata[FLAG_N-1:0] : '0;
  assign ctrl_we = reg_we && reg_addr == ADDR_CTRL;

  sticky_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_pend), .clr_i(clr_req), .flag_q(flags)
  );

  irq_ctrl_reg #(.N(FLAG_N)) u_ctrl (
    .clk(clk), .rst(rst), .we(ctrl_we), .wdata(reg_wdata[FLAG_N-1:0]),
    .en_q(irq_en)
  );

  assign status    = {{PAD_W{1'b0}}, flags};
  assign reg_rdata = (reg_addr == ADDR_CTRL) ? {{PAD_W{1'b0}}, irq_en} : status;
  assign irq_sgl   = flags[SGL_IDX] & irq_en[SGL_IDX];
  assign irq_dbl   = flags[DBL_IDX] & irq_en[DBL_IDX];
endmodule

// File: rtl/ecc_fault_capture_chk.sv
module ecc_fault_capture_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_valid,
  input logic       dbit_err,
  input logic       cmd_busy,
  input logic       reg_we,
  input logic       reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] status,
  input logic [1:0] irq_en,
  input logic       irq_sgl,
  input logic       irq_dbl
);
  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status[7:2] == 6'd0);

  // R4
  collision_both_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && cmd_busy) |=> ##1 (status[1:0] == 2'b11));

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && cmd_busy && !status[1] && !$past(rd_valid)) |=> !status[1]);

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 1'b0 && reg_wdata[0] && !$past(rd_valid)) |=> !status[0]);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_valid && dbit_err) && reg_we && reg_addr == 1'b0 && reg_wdata[1])
      |=> status[1]);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_dbl == (status[1] && irq_en[1])) && (irq_sgl == (status[0] && irq_en[0])));
endmodule

bind ecc_fault_capture ecc_fault_capture_chk u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .dbit_err(dbit_err),
  .cmd_busy(cmd_busy), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .status(status), .irq_en(irq_en),
  .irq_sgl(irq_sgl), .irq_dbl(irq_dbl)
);

// File: tb/sim_ecc_fault_capture.sv
module sim_ecc_fault_capture;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, rd_valid, sbit_fix, dbit_err, cmd_busy, ign_single;
  logic reg_we, reg_addr;
  logic [7:0] reg_wdata, reg_rdata, status;
  logic irq_sgl, irq_dbl;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_fault_capture u0 (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .sbit_fix(sbit_fix),
    .dbit_err(dbit_err), .cmd_busy(cmd_busy), .ign_single(ign_single),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .status(status), .irq_sgl(irq_sgl), .irq_dbl(irq_dbl)
  );

  function automatic logic [1:0] ref_set(logic s, logic d, logic b, logic m);
    if (b) return 2'b11;
    if (d) return 2'b10;
    if (s && !m) return 2'b01;
    return 2'b00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_ev(logic s, logic d, logic b, logic m);
    rd_valid = 1'b1; sbit_fix = s; dbit_err = d; cmd_busy = b; ign_single = m;
    step();
    rd_valid = 1'b0; sbit_fix = 1'b0; dbit_err = 1'b0; cmd_busy = 1'b0; ign_single = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; rd_valid = 0; sbit_fix = 0; dbit_err = 0; cmd_busy = 0;
    ign_single = 0; reg_we = 0; reg_addr = 0; reg_wdata = '0;
    step(); step();
    rst = 1'b0;
    check("R10 status", status, 8'h00);
    reg_addr = 1'b1;
    #1 check("R10 enables", reg_rdata, 8'h00);
    reg_addr = 1'b0;

    // R3 R4 R5 R6: full sweep of decoder inputs, busy and mask
    for (int v = 0; v < 16; v++) begin
      logic [1:0] e;
      wr(1'b0, 8'hFF);
      e = ref_set(v[0], v[1], v[2], v[3]);
      rd_ev(v[0], v[1], v[2], v[3]);
      check("R5 not yet visible", status, 8'h00);
      step();
      check(v[2] ? "R4 collision" : (v[3] ? "R6 mask" : "R3 genuine"),
            status, {6'd0, e});
      #1 check("R1 readback", reg_rdata, {6'd0, e});
    end

    // R2: write-one clears only its own bit
    wr(1'b0, 8'hFF);
    rd_ev(1'b0, 1'b0, 1'b1, 1'b0); step();
    check("R4 setup", status, 8'h03);
    wr(1'b0, 8'h00);
    check("R2 zero write", status, 8'h03);
    wr(1'b0, 8'hFD);
    check("R2 clear bit0", status, 8'h02);
    wr(1'b0, 8'h02);
    check("R2 clear bit1", status, 8'h00);

    // R7: clear in same edge as pending set
    rd_ev(1'b0, 1'b0, 1'b1, 1'b0); step();
    rd_ev(1'b0, 1'b1, 1'b0, 1'b0);
    wr(1'b0, 8'h03);
    check("R7 set beats clear", status, 8'h02);

    // R11: inputs ignored without rd_valid
    wr(1'b0, 8'h03);
    sbit_fix = 1; dbit_err = 1; cmd_busy = 1;
    step(); step(); step();
    sbit_fix = 0; dbit_err = 0; cmd_busy = 0;
    check("R11 no read", status, 8'h00);

    // R8 R9: enables and interrupt gating
    wr(1'b1, 8'hFF);
    reg_addr = 1'b1;
    #1 check("R8 ctrl readback", reg_rdata, 8'h03);
    reg_addr = 1'b0;
    for (int en = 0; en < 4; en++) begin
      for (int f = 0; f < 4; f++) begin
        wr(1'b1, en[7:0]);
        wr(1'b0, 8'h03);
        if (f == 3) begin rd_ev(1'b0, 1'b0, 1'b1, 1'b0); step(); end
        else if (f == 2) begin rd_ev(1'b0, 1'b1, 1'b0, 1'b0); step(); end
        else if (f == 1) begin rd_ev(1'b1, 1'b0, 1'b0, 1'b0); step(); end
        check("R9 irq lines", {6'd0, irq_dbl, irq_sgl}, {6'd0, f[1] & en[1], f[0] & en[0]});
      end
    end

    // R10: reset clears flags and enables
    wr(1'b1, 8'h03);
    rd_ev(1'b0, 1'b0, 1'b1, 1'b0); step();
    rst = 1'b1; step(); rst = 1'b0;
    check("R10 flags after reset", status, 8'h00);
    reg_addr = 1'b1;
    #1 check("R10 enables after reset", reg_rdata, 8'h00);
    reg_addr = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule